// File: doc/BRIEF.md
# Unsigned Array Multiply-Accumulate

This block forms the sum of a product and an addend, P = X·Y + K, for unsigned operands X, Y and K, each N bits wide. It has no clock and no state. Each bit of Y gates a copy of X through a plane of AND gates. Each gated copy is then summed into a running total by one row of full adders. The addend K is the starting value of the running total, so the array adds it with no extra adder stage.

The result is 2N bits wide. This covers the largest possible value, (2^N−1)² + (2^N−1) = 2^2N − 2^N, so no overflow indication exists. The reference width is N = 4. Any width from 2 to 16 can be built, and other widths are rejected at elaboration. A binary point is not represented in the hardware. If X has a fractional bits and Y has b fractional bits, P is read with a+b fractional bits, and K must be aligned to that scale.

Top module: `mac_array_unsigned`

## Requirements
- R1: For every combination of the N-bit inputs x, y and k, p equals x·y + k as an unsigned 2N-bit value. With N = 4, all 4096 combinations are covered.
- R2: With k = 0, x = 4'b1011 (11) and y = 4'b1110 (14) give p = 8'b10011010 (154).
- R3: At the maximum inputs (all ones), p is 2^2N − 2^N, which is 240 for N = 4. p never exceeds this value, and no overflow output exists.
- R4: When x or y is zero, p equals k, zero-extended to 2N bits.
- R5: When y = 1, p equals x + k.
- R6: p depends only on the present inputs. It follows an input change with no clock edge in between.
- R7: Bit 0 of p equals (x[0] AND y[0]) XOR k[0].
- R8: The width parameter N sets the operand width to N and the result width to 2N. The N = 3 build computes x·y + k in 6 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x | input | N | Unsigned multiplicand |
| y | input | N | Unsigned multiplier; bit i selects the row that carries x shifted left by i |
| k | input | N | Unsigned addend, fed into the first adder row |
| p | output | 2N | Unsigned result x·y + k |

## Verification
The block is combinational, so every result is due after the inputs settle. No clock edge is needed. The driver changes the operands just after a rising edge and queues the expected value. The monitor compares the output half a period later, at the falling edge, so each comparison sees only the operands of its own vector.

A separate set of checks changes the inputs and compares the output after a short delay with no edge in between. This shows that the output does not wait for a clock (R6).

// File: rtl/mac_array_pkg.sv
package mac_array_pkg;

   // Operand widths the array is built and checked for
   localparam int unsigned MIN_WIDTH = 2;
   localparam int unsigned MAX_WIDTH = 16;

   // The result of an N x N multiply plus an N-bit addend needs 2N bits
   function automatic int unsigned result_width(input int unsigned n);
      return 2 * n;
   endfunction

endpackage

// File: rtl/mac_fa.sv
module mac_fa (
   input  logic a,
   input  logic b,
   input  logic ci,
   output logic s,
   output logic co
);

   always_comb begin
      s  = a ^ b ^ ci;
      co = (a & b) | (ci & (a ^ b));
   end

endmodule

// File: rtl/mac_pp_plane.sv
module mac_pp_plane #(
   parameter int unsigned N = 4
) (
   input  logic [N-1:0] x,
   input  logic [N-1:0] y,
   output logic [N-1:0] pp [N]
);

   // Row r carries x gated by y[r]; the shift by r comes from the row's
   // position in the adder array
   for (genvar r = 0; r < N; r++) begin : g_row
      for (genvar c = 0; c < N; c++) begin : g_col
         assign pp[r][c] = x[c] & y[r];
      end
   end

endmodule

// File: rtl/mac_fa_row.sv
module mac_fa_row #(
   parameter int unsigned N = 4
) (
   input  logic [N-1:0] a,
   input  logic [N-1:0] b,
   input  logic         ci,
   output logic [N-1:0] s,
   output logic         co
);

   logic [N:0] carry;

   assign carry[0] = ci;

   for (genvar c = 0; c < N; c++) begin : g_cell
      mac_fa u_fa (
         .a  (a[c]),
         .b  (b[c]),
         .ci (carry[c]),
         .s  (s[c]),
         .co (carry[c+1])
      );
   end

   assign co = carry[N];

endmodule

// File: rtl/mac_array_unsigned.sv
module mac_array_unsigned
   import mac_array_pkg::*;
#(
   parameter int unsigned N = 4
) (
   input  logic [N-1:0]                 x,
   input  logic [N-1:0]                 y,
   input  logic [N-1:0]                 k,
   output logic [result_width(N)-1:0]   p
);

   localparam int unsigned PW = result_width(N);
   // Largest result: (2^N-1)^2 + (2^N-1) = 2^2N - 2^N (ones over zeros)
   localparam logic [PW-1:0] MAX_P = {{N{1'b1}}, {N{1'b0}}};

   if (N < MIN_WIDTH || N > MAX_WIDTH) begin : g_bad_width
      $error("mac_array_unsigned: N=%0d outside %0d..%0d", N, MIN_WIDTH, MAX_WIDTH);
   end

   logic [N-1:0] pp [N];
   // acc[r] holds the upper N bits of the running sum entering row r
   logic [N-1:0] acc [N+1];
   logic [N-1:0] row_sum [N];
   logic [N-1:0] row_co;
   logic [N-1:0] low_bits;

   mac_pp_plane #(.N(N)) u_pp (
      .x  (x),
      .y  (y),
      .pp (pp)
   );

   // The addend enters as the starting running value of the first row
   assign acc[0] = k;

   for (genvar r = 0; r < N; r++) begin : g_rows
      mac_fa_row #(.N(N)) u_row (
         .a  (pp[r]),
         .b  (acc[r]),
         .ci (1'b0),
         .s  (row_sum[r]),
         .co (row_co[r])
      );
      // The lowest sum bit is final; the rest shift down for the next row
      assign low_bits[r] = row_sum[r][0];
      if (N > 1) begin : g_shift
         assign acc[r+1] = {row_co[r], row_sum[r][N-1:1]};
      end else begin : g_single
         assign acc[r+1] = row_co[r];
      end
   end

   assign p = {acc[N], low_bits};

   // Checks beside the array
   always_comb begin
      if (x == '0 || y == '0) begin
         AST_ZERO_FACTOR: assert (p == PW'(k)) else $error("zero factor: p=%0d k=%0d", p, k); // R4
      end
      if (y == N'(1)) begin
         AST_UNIT_FACTOR: assert (p == PW'(x) + PW'(k)) else $error("unit factor: p=%0d", p); // R5
      end
      AST_LSB_PARITY: assert (p[0] == ((x[0] & y[0]) ^ k[0])) else $error("lsb mismatch"); // R7
      AST_NO_OVERFLOW: assert (p <= MAX_P) else $error("result above max: %0d", p); // R3
   end

endmodule

// File: tb/tb_mac_array_unsigned.sv
module tb_mac_array_unsigned;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #5 clk = ~clk; // 100 MHz

   // Reference width 4 and a second build at width 3 (R8)
   logic [3:0] x4, y4, k4;
   logic [7:0] p4;
   logic [2:0] x3, y3, k3;
   logic [5:0] p3;

   mac_array_unsigned #(.N(4)) dut (.x(x4), .y(y4), .k(k4), .p(p4));
   mac_array_unsigned #(.N(3)) dut_w3 (.x(x3), .y(y3), .k(k3), .p(p3));

   typedef struct {
      bit         narrow;
      bit [7:0]   exp;
      string      tag;
   } item_t;

   item_t sb_q[$];
   int n_vec = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   task automatic report_summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   // Driver: apply operands after a rising edge and queue the expected value
   task automatic drive4(input int a, input int b, input int c, input string tag);
      item_t it;
      @(posedge clk);
      #1;
      x4 = 4'(a); y4 = 4'(b); k4 = 4'(c);
      it.narrow = 1'b0;
      it.exp    = 8'(a * b + c);
      it.tag    = tag;
      sb_q.push_back(it);
   endtask

   task automatic drive3(input int a, input int b, input int c, input string tag);
      item_t it;
      @(posedge clk);
      #1;
      x3 = 3'(a); y3 = 3'(b); k3 = 3'(c);
      it.narrow = 1'b1;
      it.exp    = 8'(a * b + c);
      it.tag    = tag;
      sb_q.push_back(it);
   endtask

   // Monitor: compare at the falling edge, half a period after drive
   initial begin
      forever begin
         @(negedge clk);
         if (sb_q.size() > 0) begin
            item_t it;
            bit [7:0] act;
            it  = sb_q.pop_front();
            act = it.narrow ? 8'(p3) : p4;
            n_vec++;
            if (act !== it.exp) begin
               n_bad++;
               $display("FAIL %s: p=%0d expected %0d", it.tag, act, it.exp);
            end
         end
      end
   end

   // Checks with no clock edge between input change and sampling (R6)
   task automatic direct4(input int a, input int b, input int c);
      bit [7:0] e;
      x4 = 4'(a); y4 = 4'(b); k4 = 4'(c);
      e = 8'(a * b + c);
      #1;
      n_vec++;
      if (p4 !== e) begin
         n_bad++;
         $display("FAIL R6: p=%0d expected %0d", p4, e);
      end
   endtask

   initial begin
      x4 = '0; y4 = '0; k4 = '0;
      x3 = '0; y3 = '0; k3 = '0;
      repeat (3) @(posedge clk);
      // Reset-time state: all inputs zero give zero
      #1;
      n_vec++;
      if (p4 !== 8'd0 || p3 !== 6'd0) begin
         n_bad++;
         $display("FAIL R4 reset: p4=%0d p3=%0d expected 0", p4, p3);
      end
      rst = 1'b0;

      drive4(11, 14, 0, "R2 11*14");
      drive4(15, 15, 15, "R3 max");
      drive4(15, 15, 0, "R3 max product");
      drive4(0, 9, 13, "R4 x zero");
      drive4(7, 0, 5, "R4 y zero");
      drive4(0, 0, 15, "R4 both zero");
      drive4(13, 1, 9, "R5 unit y");
      drive4(15, 1, 15, "R5 unit y carry");
      drive4(1, 1, 1, "R7 lsb cancel");
      drive4(3, 5, 0, "R7 lsb set");
      drive4(2, 3, 1, "R7 k only lsb");

      // Exhaustive sweep of the reference width (R1)
      for (int a = 0; a < 16; a++)
         for (int b = 0; b < 16; b++)
            for (int c = 0; c < 16; c++)
               drive4(a, b, c, "R1 sweep");

      // Second width build (R8)
      drive3(7, 7, 7, "R8 max w3");
      for (int a = 0; a < 8; a++)
         for (int b = 0; b < 8; b++)
            for (int c = 0; c < 8; c++)
               drive3(a, b, c, "R8 sweep w3");

      // Wait until the scoreboard drains
      while (sb_q.size() > 0) @(posedge clk);
      @(posedge clk);

      // Output follows inputs without a clock edge
      @(negedge clk);
      direct4(9, 6, 3);
      direct4(14, 11, 7);
      direct4(1, 15, 0);

      finished = 1'b1;
      report_summary();
   end

   // Watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         report_summary();
      end
   end

endmodule